// File: doc/BRIEF.md
# Prioritized Interrupt Vector Encoder

This block gathers eleven interrupt sources for a small processor core and presents one request together with the vector address of the source to serve first. Three sources are external pins, whose pending requests arrive already conditioned from a separate pin unit. The other eight are timer events: overflows, compare matches and an input capture. Each timer event is latched into a flag bit. A byte-wide enable register holds one enable bit per timer flag. Software can read and write both registers.

A source is eligible when its flag (or pin request), its enable and the global enable input are all set. Among eligible sources, the one with the lowest vector address wins. When the core takes the vector, it asserts a take strobe for one cycle. If the winner is a timer, its flag is cleared. If the winner is a pin, a one-hot acknowledge goes back to the pin unit. Request and vector follow the registered state combinationally, so a higher-priority source that appears before the take displaces the current winner.

Top module: `irqv_top`

## Requirements
- R1: After reset, the timer enable register and the timer flag register both read 0x00, and `irq_req` is low.
- R2: With `reg_sel`=0, a write stores `reg_wdata` in the enable register, and a read returns it unchanged. With `reg_sel`=1, reads return the flag register.
- R3: A one on `tmr_evt[b]` sets flag bit b at the next clock edge. The bit meanings are: 7 timer1 overflow, 6 timer1 compare A, 5 timer1 compare B, 4 timer2 overflow, 3 timer1 capture, 2 timer2 compare, 1 timer0 overflow, 0 timer0 compare. `dir_turn` also sets bit 7.
- R4: A write with `reg_sel`=1 clears every flag bit where `reg_wdata` holds a one. Bits written with zero are left unchanged.
- R5: `irq_req` is high only when `glob_en` is high and at least one `pin_req` bit or one (flag AND enable) bit is set. `pin_req` bits need no enable bit.
- R6: Vectors are pin0 0x02, pin1 0x04, pin2 0x06, timer2 compare 0x08, timer2 overflow 0x0A, timer1 capture 0x0C, timer1 compare A 0x0E, timer1 compare B 0x10, timer1 overflow 0x12, timer0 compare 0x14, timer0 overflow 0x16. The lowest eligible vector is output. `irq_vec` is 0 when there is no request.
- R7: A `take` pulse while a timer source wins clears only that source's flag at the next edge.
- R8: A `take` pulse while pin k wins raises only `pin_ack[k]` for that cycle, and leaves the timer flags unchanged. `pin_ack` is zero when `take` is low.
- R9: A set event in the same cycle as a write-one clear or a take clear leaves the flag set.
- R10: `irq_req` and `irq_vec` follow the current state within the same cycle. A newly eligible higher-priority source replaces the winner without any take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 enable, 1 flags |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| glob_en | input | 1 | Global interrupt enable |
| pin_req | input | 3 | Pending requests from the pin unit |
| tmr_evt | input | 8 | Timer event pulses, one per flag bit |
| dir_turn | input | 1 | Timer1 direction change at zero (sets bit 7) |
| take | input | 1 | Core takes the current vector |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector address of the winner |
| pin_ack | output | 3 | One-hot acknowledge to the pin unit |

## Verification
A stuck or lost flag bit shows one cycle after its event, either in a flag read-back or as a wrong vector. A wrongly wired flag position shows in the same way. A priority fault appears at once whenever two eligible sources overlap, because the vector is combinational. An acknowledge that clears the wrong source shows one cycle after `take`, as a vector that does not advance to the next source, or in the flag read-back.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int PIN_N  = 3;
   localparam int TMR_N  = 8;
   localparam int SRC_N  = PIN_N + TMR_N;
   localparam int SLOT_W = $clog2(SRC_N);

   // priority slot (after the pins) -> flag bit position
   function automatic int slot_bit(input int s);
      case (s)
         0: return 2;   // timer2 compare
         1: return 4;   // timer2 overflow
         2: return 3;   // timer1 capture
         3: return 6;   // timer1 compare A
         4: return 5;   // timer1 compare B
         5: return 7;   // timer1 overflow
         6: return 0;   // timer0 compare
         default: return 1; // timer0 overflow
      endcase
   endfunction
endpackage

// File: rtl/irqv_flag_reg.sv
module irqv_flag_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] wclr_i,
   input  logic [W-1:0] aclr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] nxt;

   always_comb nxt = (q_o & ~(wclr_i | aclr_i)) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
   parameter int N     = 11,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [N-1:0]     hot_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_slot
         assign hot_o[i]  = req_i[i] & ~seen[i];
         assign seen[i+1] = seen[i] | req_i[i];
      end
   endgenerate

   assign any_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--)
         if (req_i[k]) idx_o = IDX_W'(k);
   end
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
   parameter int VEC_W     = 8,
   parameter int VEC_FIRST = 2,
   parameter int VEC_STEP  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_sel,
   input  logic                      reg_wr,
   input  logic [7:0]                reg_wdata,
   output logic [7:0]                reg_rdata,
   input  logic                      glob_en,
   input  logic [irqv_pkg::PIN_N-1:0] pin_req,
   input  logic [7:0]                tmr_evt,
   input  logic                      dir_turn,
   input  logic                      take,
   output logic                      irq_req,
   output logic [VEC_W-1:0]          irq_vec,
   output logic [irqv_pkg::PIN_N-1:0] pin_ack
);
   import irqv_pkg::*;

   localparam int VEC_LAST = VEC_FIRST + VEC_STEP * (SRC_N - 1);

   if (VEC_LAST >= (1 << VEC_W)) begin : g_bad_width
      $error("irqv_top: VEC_W too narrow for the vector table");
   end
   if (VEC_STEP < 1) begin : g_bad_step
      $error("irqv_top: VEC_STEP must be positive");
   end

   logic [TMR_N-1:0] en_q, flag_q, set_v, wclr_v, aclr_v;
   logic [SRC_N-1:0] elig, hot;
   logic [SLOT_W-1:0] win_idx;
   logic              any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 en_q <= '0;
      else if (reg_wr && !reg_sel) en_q <= reg_wdata;
   end

   assign set_v  = tmr_evt | {dir_turn, {(TMR_N-1){1'b0}}};
   assign wclr_v = (reg_wr && reg_sel) ? reg_wdata : '0;

   irqv_flag_reg #(.W(TMR_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_v),
      .wclr_i(wclr_v), .aclr_i(aclr_v), .q_o(flag_q)
   );

   genvar s;
   generate
      for (s = 0; s < PIN_N; s++) begin : g_pin
         assign elig[s]    = glob_en & pin_req[s];
         assign pin_ack[s] = take & hot[s];
      end
      for (s = 0; s < TMR_N; s++) begin : g_tmr
         localparam int B = slot_bit(s);
         assign elig[PIN_N+s] = glob_en & flag_q[B] & en_q[B];
         assign aclr_v[B]     = take & hot[PIN_N+s];
      end
   endgenerate

   irqv_prio_enc #(.N(SRC_N), .IDX_W(SLOT_W)) u_enc (
      .req_i(elig), .any_o(any), .hot_o(hot), .idx_o(win_idx)
   );

   assign irq_req   = any;
   assign irq_vec   = any ? VEC_W'(VEC_FIRST + VEC_STEP * int'(win_idx)) : '0;
   assign reg_rdata = reg_sel ? flag_q : en_q;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_sel,
   input logic       reg_wr,
   input logic       glob_en,
   input logic [7:0] tmr_evt,
   input logic       dir_turn,
   input logic       take,
   input logic [7:0] flag_q,
   input logic       irq_req,
   input logic [7:0] irq_vec,
   input logic [2:0] pin_ack
);
   logic [7:0] evt_all;
   assign evt_all = tmr_evt | {dir_turn, 7'b0};

   assert_flag_rise_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_all)) == 8'h00));

   assert_flag_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((~flag_q & $past(flag_q)) == 8'h00) || $past(take) || $past(reg_wr && reg_sel)));

   assert_no_req_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> !irq_req);

   assert_vec_in_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[0] == 1'b0 && irq_vec >= 8'h02 && irq_vec <= 8'h16));

   assert_vec_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == 8'h00));

   assert_pin_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pin_ack));

   assert_pin_ack_needs_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_ack != 3'b000) |-> (take && irq_req && irq_vec <= 8'h06));
endmodule

bind irqv_top irqv_checker u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
   .glob_en(glob_en), .tmr_evt(tmr_evt), .dir_turn(dir_turn), .take(take),
   .flag_q(flag_q), .irq_req(irq_req), .irq_vec(irq_vec), .pin_ack(pin_ack)
);

// File: tb/irqv_top_test.sv
module irqv_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       glob_en = 1'b0;
   logic [2:0] pin_req = 3'b000;
   logic [7:0] tmr_evt = 8'h00;
   logic       dir_turn = 1'b0, take = 1'b0;
   logic       irq_req;
   logic [7:0] irq_vec;
   logic [2:0] pin_ack;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irqv_top uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_en(glob_en),
      .pin_req(pin_req), .tmr_evt(tmr_evt), .dir_turn(dir_turn), .take(take),
      .irq_req(irq_req), .irq_vec(irq_vec), .pin_ack(pin_ack)
   );

   // {enable, events, pins, glob, exp_req, exp_vec}
   localparam int NV = 12;
   localparam logic [28:0] VECS [NV] = '{
      {8'hFF, 8'h01, 3'b000, 1'b1, 1'b1, 8'h14},
      {8'hFF, 8'h03, 3'b000, 1'b1, 1'b1, 8'h14},
      {8'hFF, 8'h80, 3'b100, 1'b1, 1'b1, 8'h06},
      {8'hFF, 8'hFF, 3'b000, 1'b1, 1'b1, 8'h08},
      {8'h00, 8'hFF, 3'b000, 1'b1, 1'b0, 8'h00},
      {8'hFF, 8'hFF, 3'b111, 1'b0, 1'b0, 8'h00},
      {8'hFB, 8'hFF, 3'b000, 1'b1, 1'b1, 8'h0A},
      {8'hEB, 8'hFF, 3'b000, 1'b1, 1'b1, 8'h0C},
      {8'h80, 8'hA0, 3'b000, 1'b1, 1'b1, 8'h12},
      {8'h60, 8'h20, 3'b000, 1'b1, 1'b1, 8'h10},
      {8'h00, 8'h00, 3'b011, 1'b1, 1'b1, 8'h02},
      {8'h40, 8'h40, 3'b000, 1'b1, 1'b1, 8'h0E}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d);
      reg_sel = sel; #1 d = reg_rdata;
   endtask

   task automatic pulse_evt(input logic [7:0] e);
      tmr_evt = e; @(negedge clk); tmr_evt = 8'h00;
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (2) @(negedge clk);
      // R1 reset state
      rd(1'b0, d); chk("R1 enable", d, 8'h00);
      rd(1'b1, d); chk("R1 flags", d, 8'h00);
      chk("R1 req", {7'b0, irq_req}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk (R5, R6)
      for (int i = 0; i < NV; i++) begin
         glob_en = 1'b0; pin_req = 3'b000;
         wr(1'b1, 8'hFF);
         wr(1'b0, VECS[i][28:21]);
         pulse_evt(VECS[i][20:13]);
         pin_req = VECS[i][12:10]; glob_en = VECS[i][9];
         #1;
         chk("R5 req", {7'b0, irq_req}, {7'b0, VECS[i][8]});
         chk("R6 vec", irq_vec, VECS[i][7:0]);
         @(negedge clk);
      end
      glob_en = 1'b0; pin_req = 3'b000;

      // R2 enable read-back
      wr(1'b0, 8'hA5); rd(1'b0, d); chk("R2 enable rw", d, 8'hA5);

      // R3 each event bit and dir_turn
      wr(1'b1, 8'hFF);
      for (int b = 0; b < 8; b++) begin
         pulse_evt(8'h01 << b); rd(1'b1, d);
         chk("R3 flag bit", d, 8'h01 << b);
         wr(1'b1, 8'hFF);
      end
      dir_turn = 1'b1; @(negedge clk); dir_turn = 1'b0;
      rd(1'b1, d); chk("R3 dir_turn", d, 8'h80);

      // R4 write-one clear
      pulse_evt(8'hFF);
      wr(1'b1, 8'h0F); rd(1'b1, d); chk("R4 clear ones", d, 8'hF0);
      wr(1'b1, 8'h00); rd(1'b1, d); chk("R4 zero keeps", d, 8'hF0);

      // R7 take clears only winner
      pulse_evt(8'hFF); wr(1'b0, 8'hFF); glob_en = 1'b1;
      #1 chk("R7 before", irq_vec, 8'h08);
      @(negedge clk); take = 1'b1; @(negedge clk); take = 1'b0;
      rd(1'b1, d); chk("R7 flags", d, 8'hFB);
      chk("R7 next vec", irq_vec, 8'h0A);

      // R8 pin winner ack
      pin_req = 3'b010; #1;
      take = 1'b1; #1;
      chk("R8 pin_ack", {5'b0, pin_ack}, 8'h02);
      @(negedge clk); take = 1'b0; pin_req = 3'b000; #1;
      chk("R8 idle ack", {5'b0, pin_ack}, 8'h00);
      rd(1'b1, d); chk("R8 flags kept", d, 8'hFB);

      // R9 set wins over clear
      wr(1'b1, 8'hFF);
      pulse_evt(8'h01);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h01; tmr_evt = 8'h01;
      @(negedge clk); reg_wr = 1'b0; tmr_evt = 8'h00;
      rd(1'b1, d); chk("R9 write vs set", d, 8'h01);
      wr(1'b0, 8'h01); #1 chk("R9 winner", irq_vec, 8'h14);
      take = 1'b1; tmr_evt = 8'h01; @(negedge clk); take = 1'b0; tmr_evt = 8'h00;
      rd(1'b1, d); chk("R9 take vs set", d, 8'h01);

      // R10 combinational takeover
      wr(1'b1, 8'hFF); wr(1'b0, 8'h02); pulse_evt(8'h02);
      #1 chk("R10 low prio", irq_vec, 8'h16);
      pin_req = 3'b010; #1;
      chk("R10 takeover", irq_vec, 8'h04);
      pin_req = 3'b000;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule